// File: doc/BRIEF.md
# Variable-Length Instruction Line Cracker

This block sits at the front of an instruction decode path. It takes a stream of fixed-size cache lines and produces a stream of variable-length instructions, one at a time. It holds two lines in a window, reads the length of the next instruction from its first byte, and hands the instruction out once every byte of it is in the window. An instruction may be as long as a whole line, so it can start in the first buffered line and end in the second.

Lines enter through a fill port. The block shows the byte address of the next sequential line it wants and accepts a line whenever its second slot is free. When the read point moves past the end of the first line, that line is dropped and the second line moves down. A taken-branch prediction or a mispredict both load a fresh pair of lines together with a target byte address. The offset of the target within its line sets the read point. A predicted transfer keeps an instruction that is already waiting at the output. A mispredict drops it. Outputs carry the instruction bytes, the length and the start address, with no notion of which line they came from.

Top module: `crk_line_cracker`

## Requirements
- R1: After reset the output is not valid, `fill_ready` is 1 and `fill_addr` equals `RESET_ADDR` (0 by default).
- R2: The low six bits of an instruction's first byte give its length in bytes. A value n from 1 to 63 means n bytes, and 0 means 64 bytes. `out_len` reports that length.
- R3: Byte k of the instruction, counted from its first byte, appears on `out_insn[8k+7:8k]`. Every lane at or above `out_len` is zero.
- R4: `out_addr` is the byte address of the instruction's first byte. Without a redirect, each accepted instruction starts at the previous address plus the previous length.
- R5: An instruction whose bytes run past the end of the first buffered line is assembled correctly from both lines.
- R6: No instruction is presented until all of its bytes are in the window. With no lines filled, `out_valid` stays 0.
- R7: `fill_addr` is the line address that follows the last buffered line. An accepted fill goes into the lowest empty slot. The first line is retired as soon as the read point reaches or passes its end.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output holds its instruction, length and address until accepted, unless a mispredict arrives.
- R9: A `pred_take` pulse loads `tgt_line0` and `tgt_line1` as the window and starts reading at `tgt_addr`. Buffered bytes of the old stream are discarded, but an instruction already waiting at the output is still delivered first.
- R10: A `mispredict` pulse reloads the window the same way as R9. It also clears any waiting output, so `out_valid` is 0 in the following cycle.
- R11: `fill_ready` is 0 in any cycle in which `pred_take` or `mispredict` is high, so no fill is accepted alongside a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | A line is offered on `fill_data` |
| fill_ready | output | 1 | The block accepts a line this cycle |
| fill_addr | output | ADDR_W | Byte address of the line wanted next |
| fill_data | input | LINE_BYTES*8 | Line content, byte 0 in the low bits |
| pred_take | input | 1 | Predicted taken transfer: reload the window |
| mispredict | input | 1 | Misprediction: reload the window and drop the waiting output |
| tgt_addr | input | ADDR_W | Byte address of the redirect target |
| tgt_line0 | input | LINE_BYTES*8 | Line that holds the target |
| tgt_line1 | input | LINE_BYTES*8 | Line that follows the target line |
| out_valid | output | 1 | An instruction is presented |
| out_ready | input | 1 | The consumer takes the instruction |
| out_insn | output | LINE_BYTES*8 | Instruction bytes, first byte in lane 0, zero-padded |
| out_len | output | $clog2(LINE_BYTES)+1 | Instruction length in bytes |
| out_addr | output | ADDR_W | Byte address of the first instruction byte |

## Verification
The hardest case to reach is a predicted transfer that arrives while the output is held by backpressure and the window holds only one line, with the next instruction straddling into the missing line. The held instruction must come out first and the target stream must follow. The stimulus walks a program whose lengths cycle through every value from 1 to 64, so straddles happen at every offset. It throttles `out_ready` and `fill_valid` from a shift register and fires redirects only in cycles where `out_ready` is low. Predicted transfers and mispredicts alternate, and the target table is stepped through in a fixed stride.

// File: rtl/crk_pkg.sv
package crk_pkg;
    typedef enum logic [1:0] {
        REDIR_NONE  = 2'd0,
        REDIR_TAKEN = 2'd1,
        REDIR_MISS  = 2'd2
    } redir_e;
endpackage

// File: rtl/crk_len_decode.sv
module crk_len_decode #(
    parameter int LINE_BYTES = 64,
    localparam int PTR_W = $clog2(LINE_BYTES),
    localparam int LEN_W = PTR_W + 1
) (
    input  logic [7:0]       hdr,
    output logic [LEN_W-1:0] len
);
    logic [PTR_W-1:0] code;
    assign code = hdr[PTR_W-1:0];
    // code zero stands for a full line
    assign len = (code == '0) ? LEN_W'(LINE_BYTES) : {1'b0, code};
endmodule

// File: rtl/crk_align.sv
module crk_align #(
    parameter int LINE_BYTES = 64,
    localparam int PTR_W = $clog2(LINE_BYTES),
    localparam int LEN_W = PTR_W + 1,
    localparam int LW    = LINE_BYTES * 8
) (
    input  logic [2*LW-1:0]  win,
    input  logic [PTR_W-1:0] rd,
    input  logic [LEN_W-1:0] len,
    output logic [LW-1:0]    insn
);
    logic [2*LW-1:0] shifted;
    assign shifted = win >> {rd, 3'b000};

    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_lane
        assign insn[k*8 +: 8] = (LEN_W'(k) < len) ? shifted[k*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/crk_line_cracker.sv
module crk_line_cracker
    import crk_pkg::*;
#(
    parameter int          LINE_BYTES = 64,
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] RESET_ADDR = 32'h0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fill_valid,
    output logic                      fill_ready,
    output logic [ADDR_W-1:0]         fill_addr,
    input  logic [LINE_BYTES*8-1:0]   fill_data,
    input  logic                      pred_take,
    input  logic                      mispredict,
    input  logic [ADDR_W-1:0]         tgt_addr,
    input  logic [LINE_BYTES*8-1:0]   tgt_line0,
    input  logic [LINE_BYTES*8-1:0]   tgt_line1,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [LINE_BYTES*8-1:0]   out_insn,
    output logic [$clog2(LINE_BYTES):0] out_len,
    output logic [ADDR_W-1:0]         out_addr
);
    localparam int LW    = LINE_BYTES * 8;
    localparam int PTR_W = $clog2(LINE_BYTES);
    localparam int LEN_W = PTR_W + 1;
    localparam int AV_W  = PTR_W + 2;

    typedef struct packed {
        logic [LW-1:0]     l0;
        logic [LW-1:0]     l1;
        logic              v0;
        logic              v1;
        logic [PTR_W-1:0]  rd;
        logic [ADDR_W-1:0] base;
        logic              ov;
        logic [LW-1:0]     oi;
        logic [LEN_W-1:0]  olen;
        logic [ADDR_W-1:0] oaddr;
    } st_t;

    st_t st_q, st_d;

    redir_e           kind;
    logic [7:0]       hdr;
    logic [LEN_W-1:0] dec_len;
    logic [LW-1:0]    aligned;
    logic [AV_W-1:0]  total, avail;
    logic [LEN_W-1:0] nxt;
    logic             out_free, fire;

    assign kind = mispredict ? REDIR_MISS : (pred_take ? REDIR_TAKEN : REDIR_NONE);
    assign hdr  = st_q.l0[{st_q.rd, 3'b000} +: 8];

    crk_len_decode #(.LINE_BYTES(LINE_BYTES)) u_len (
        .hdr (hdr),
        .len (dec_len)
    );

    crk_align #(.LINE_BYTES(LINE_BYTES)) u_align (
        .win  ({st_q.l1, st_q.l0}),
        .rd   (st_q.rd),
        .len  (dec_len),
        .insn (aligned)
    );

    assign total    = st_q.v1 ? AV_W'(2 * LINE_BYTES) : (st_q.v0 ? AV_W'(LINE_BYTES) : '0);
    assign avail    = total - AV_W'(st_q.rd);
    assign out_free = !st_q.ov || out_ready;
    assign fire     = (kind == REDIR_NONE) && st_q.v0 && (AV_W'(dec_len) <= avail) && out_free;
    assign nxt      = {1'b0, st_q.rd} + dec_len;

    assign fill_ready = !st_q.v1 && (kind == REDIR_NONE);
    assign fill_addr  = st_q.base + (st_q.v0 ? ADDR_W'(LINE_BYTES) : '0);

    always_comb begin
        st_d = st_q;
        if (st_q.ov && out_ready) begin
            st_d.ov = 1'b0;
        end
        if (fire) begin
            st_d.ov    = 1'b1;
            st_d.oi    = aligned;
            st_d.olen  = dec_len;
            st_d.oaddr = st_q.base + ADDR_W'(st_q.rd);
            st_d.rd    = nxt[PTR_W-1:0];
            if (nxt[PTR_W]) begin
                st_d.l0   = st_q.l1;
                st_d.v0   = st_q.v1;
                st_d.v1   = 1'b0;
                st_d.base = st_q.base + ADDR_W'(LINE_BYTES);
            end
        end
        if (fill_valid && fill_ready) begin
            if (!st_d.v0) begin
                st_d.l0 = fill_data;
                st_d.v0 = 1'b1;
            end else begin
                st_d.l1 = fill_data;
                st_d.v1 = 1'b1;
            end
        end
        if (kind != REDIR_NONE) begin
            st_d.l0   = tgt_line0;
            st_d.l1   = tgt_line1;
            st_d.v0   = 1'b1;
            st_d.v1   = 1'b1;
            st_d.rd   = tgt_addr[PTR_W-1:0];
            st_d.base = {tgt_addr[ADDR_W-1:PTR_W], {PTR_W{1'b0}}};
            if (kind == REDIR_MISS) begin
                st_d.ov = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.base <= {RESET_ADDR[ADDR_W-1:PTR_W], {PTR_W{1'b0}}};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_insn  = st_q.oi;
    assign out_len   = st_q.olen;
    assign out_addr  = st_q.oaddr;
endmodule

// File: rtl/crk_checker.sv
module crk_checker #(
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    localparam int LEN_W = $clog2(LINE_BYTES) + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pred_take,
    input logic                    mispredict,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LINE_BYTES*8-1:0] out_insn,
    input logic [LEN_W-1:0]        out_len,
    input logic [ADDR_W-1:0]       out_addr
);
    logic              have_q, skip_q;
    logic [ADDR_W-1:0] end_q;
    logic              pad_ok;

    always_comb begin
        pad_ok = 1'b1;
        for (int k = 0; k < LINE_BYTES; k++) begin
            if ((LEN_W'(k) >= out_len) && (out_insn[k*8 +: 8] != 8'h00)) begin
                pad_ok = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            skip_q <= 1'b0;
            end_q  <= '0;
        end else if (pred_take || mispredict) begin
            have_q <= 1'b0;
            skip_q <= pred_take && !mispredict && out_valid && !out_ready;
        end else if (out_valid && out_ready) begin
            if (skip_q) begin
                skip_q <= 1'b0;
            end else begin
                have_q <= 1'b1;
                end_q  <= out_addr + ADDR_W'(out_len);
            end
        end
    end

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(LINE_BYTES))); // R2
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> pad_ok); // R3
    AST_ADDR_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (have_q && out_valid && out_ready && !pred_take && !mispredict) |-> (out_addr == end_q)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !mispredict) |=>
            (out_valid && $stable(out_insn) && $stable(out_len) && $stable(out_addr))); // R8
    AST_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |=> !out_valid); // R10
endmodule

bind crk_line_cracker crk_checker #(.LINE_BYTES(LINE_BYTES), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pred_take  (pred_take),
    .mispredict (mispredict),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_insn   (out_insn),
    .out_len    (out_len),
    .out_addr   (out_addr)
);

// File: tb/tb_crk_line_cracker.sv
module tb_crk_line_cracker;
    localparam int CLK_PERIOD = 10;
    localparam int LB    = 64;
    localparam int MEMSZ = 4096;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fill_valid = 1'b0;
    logic         fill_ready;
    logic [31:0]  fill_addr;
    logic [511:0] fill_data = '0;
    logic         pred_take = 1'b0;
    logic         mispredict = 1'b0;
    logic [31:0]  tgt_addr = '0;
    logic [511:0] tgt_line0 = '0;
    logic [511:0] tgt_line1 = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [511:0] out_insn;
    logic [6:0]   out_len;
    logic [31:0]  out_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    crk_line_cracker dut (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr), .fill_data(fill_data),
        .pred_take(pred_take), .mispredict(mispredict), .tgt_addr(tgt_addr),
        .tgt_line0(tgt_line0), .tgt_line1(tgt_line1),
        .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
        .out_len(out_len), .out_addr(out_addr)
    );

    logic [7:0] mem [MEMSZ];
    int starts [256];
    int n_starts;
    int vectors = 0;
    int fails = 0;
    int exp_next = 0;
    int exp_fill = 0;
    int pend = 0;
    int pend_tgt = 0;
    int after = 0;       // 0 none, 1 taken, 2 miss
    int pend_after = 0;
    bit held = 0;
    logic [511:0] h_insn;
    logic [6:0]   h_len;
    logic [31:0]  h_addr;
    bit expect_empty = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [511:0] line_of(int a);
        logic [511:0] l;
        int b;
        b = a - (a % LB);
        for (int k = 0; k < LB; k++) l[k*8 +: 8] = mem[(b + k) % MEMSZ];
        return l;
    endfunction

    function automatic int len_at(int a);
        int c;
        c = int'(mem[a % MEMSZ][5:0]);
        return (c == 0) ? LB : c;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_out();
        logic [511:0] e;
        int L;
        L = len_at(exp_next);
        e = '0;
        for (int k = 0; k < L; k++) e[k*8 +: 8] = mem[(exp_next + k) % MEMSZ];
        check(out_addr == 32'(exp_next), (after == 1) ? "R9" : (after == 2) ? "R10" : "R4",
              "out_addr", longint'(out_addr), longint'(exp_next));
        check(out_len == 7'(L), "R2", "out_len", longint'(out_len), longint'(L));
        vectors++;
        if (out_insn !== e) begin
            fails++;
            $display("FAIL %s out_insn actual=%h expected=%h",
                     ((exp_next % LB) + L > LB) ? "R5" : "R3", out_insn, e);
        end
        exp_next = exp_next + L;
        after = 0;
        if (pend != 0) begin
            exp_next = pend_tgt;
            after = pend_after;
            pend = 0;
        end
    endtask

    // one cycle, entered and left at a falling edge
    task automatic step(bit rdy, bit fv, int rk, int tgt);
        out_ready  = rdy;
        fill_valid = fv;
        pred_take  = (rk == 1);
        mispredict = (rk == 2);
        tgt_addr   = 32'(tgt);
        tgt_line0  = line_of(tgt);
        tgt_line1  = line_of(tgt + LB);
        fill_data  = line_of(int'(fill_addr));
        #1;
        if (rk != 0) check(fill_ready == 1'b0, "R11", "fill_ready", longint'(fill_ready), 0);
        if (out_valid && out_ready) check_out();
        if (fill_valid && fill_ready) begin
            check(fill_addr == 32'(exp_fill), "R7", "fill_addr", longint'(fill_addr), longint'(exp_fill));
            exp_fill = exp_fill + LB;
        end
        held = out_valid && !out_ready && (rk != 2);
        h_insn = out_insn; h_len = out_len; h_addr = out_addr;
        expect_empty = (rk == 2);
        if (rk == 2) begin
            exp_next = tgt; pend = 0; after = 2;
        end else if (rk == 1) begin
            if (out_valid) begin
                pend = 1; pend_tgt = tgt; pend_after = 1;
            end else begin
                exp_next = tgt; after = 1;
            end
        end
        if (rk != 0) exp_fill = tgt - (tgt % LB) + 2 * LB;
        @(posedge clk);
        @(negedge clk);
        if (held) begin
            check(out_valid && out_insn == h_insn && out_len == h_len && out_addr == h_addr,
                  (rk == 1) ? "R9" : "R8", "held out_addr", longint'(out_addr), longint'(h_addr));
        end
        if (expect_empty) check(out_valid == 1'b0, "R10", "out_valid", longint'(out_valid), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int a, i, rc, guard;
        for (int x = 0; x < MEMSZ; x++) mem[x] = 8'((x * 13 + 7) ^ (x >> 5));
        a = 0; i = 0;
        while (a < MEMSZ && i < 256) begin
            int L;
            L = ((i * 37) % 64) + 1;
            mem[a] = 8'(L % 64);
            starts[i] = a;
            i++;
            a = a + L;
        end
        n_starts = i;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
        check(fill_ready == 1'b1, "R1", "fill_ready", longint'(fill_ready), 1);
        check(fill_addr == 32'h0, "R1", "fill_addr", longint'(fill_addr), 0);

        // R6: nothing appears without lines
        for (int n = 0; n < 4; n++) begin
            step(1'b1, 1'b0, 0, 0);
            check(out_valid == 1'b0, "R6", "out_valid", longint'(out_valid), 0);
        end

        // sequential stream at full rate
        guard = 0;
        while (exp_next < 3000 && guard < 20000) begin
            step(1'b1, 1'b1, 0, 0);
            guard++;
        end
        step(1'b0, 1'b0, 2, starts[5]);

        // throttled stream with alternating redirects
        rc = 0;
        for (int n = 0; n < 3000; n++) begin
            bit rdy, fv;
            int rk, tgt;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rdy = lfsr[0] | lfsr[1];
            fv  = lfsr[2] | lfsr[3];
            rk = 0; tgt = 0;
            if (pend != 0) begin
                rdy = 1'b1;
            end else if ((n % 23) == 22 || exp_next > 3500) begin
                rdy = 1'b0;
                rk  = (rc % 2 == 0) ? 1 : 2;
                tgt = starts[(rc * 29) % 100];
                rc++;
            end
            step(rdy, fv, rk, tgt);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule